// File: doc/BRIEF.md
# GPIO Expander Port Register Core

This block is the register and pin logic behind an 8-bit general-purpose I/O expander. A host reaches it over a simple synchronous register bus: a register index, write data with a write strobe, and a read strobe with registered read data. Four registers sit behind that bus: a captured input register, an output value register, a polarity mask, and a direction register. The serial bus slave in front of it, the pads and their drive strengths are all outside this block.

Each pin has its own direction bit. Pins set as outputs drive the output register's bit. Pins set as inputs are sampled through a two-flop synchronizer. A read of the input register returns the synchronized pin values XORed with the polarity mask, and the same read loads the raw synchronized values into the captured input register. An open-drain style interrupt pulls low while any input-direction pin differs from its captured value. Reading the input register clears it, and it also clears when the pins return to the captured values.

Top module: `gpio_xp_core`

## Requirements
- R1: While `rst_n` is low and after its release, the output register is 0xFF, the polarity mask is 0x00, the direction register is 0xFF, the captured input register is 0x00, `rd_data` is 0x00, `pin_oe` is 0x00 and `irq_pull` is 0.
- R2: Direction bit i set to 1 makes pin i an input, and 0 makes it an output. `pin_oe[i]` is the inverse of direction bit i, and each bit is independent of the others. A write takes effect on the next cycle.
- R3: `pin_out` always equals the output register, which index 1 writes.
- R4: The index map is 0 = captured input, 1 = output, 2 = polarity, 3 = direction. `rd_data` updates on the clock edge that samples `rd_en`. Indexes 4 to 7 read as 0x00, and `rd_data` holds its value while `rd_en` is low.
- R5: Writes to index 0 and to indexes 4 to 7 change no register.
- R6: A read of index 0 returns the pins, delayed two clocks by the synchronizer and XORed with the polarity mask. It also loads the uninverted synchronized pin values into the captured input register.
- R7: `irq_pull` is 1 in the cycle after any input-direction pin's synchronized value differs from the captured input register. A pin edge therefore reaches `irq_pull` on the third clock edge.
- R8: A read of index 0 forces `irq_pull` to 0 on the next cycle. `irq_pull` also drops when the pins return to the captured values.
- R9: Pins whose direction bit is 0 never cause `irq_pull`. Switching a differing pin back to input direction raises `irq_pull`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_idx | input | 3 | Register index for a read or a write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| irq_pull | output | 1 | Interrupt pull-down enable (1 pulls the active-low line low) |

## Verification
The pins are driven with several patterns. A multi-bit change under a non-zero polarity mask shows whether inversion is applied to read data only and not to the captured value. A single-bit change is timed edge by edge to pin down the synchronizer plus interrupt latency. A change that reverts without a read separates self-clearing from read-clearing. An all-ones change with every pin set as output, followed by a switch back to input direction, shows the direction masking of the comparison. A write to index 0 with input-direction pins held low is observed through `irq_pull`. A corrupted captured register would raise it.

// File: rtl/gpio_xp_pkg.sv
package gpio_xp_pkg;

  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_IN  = 3'd0,
    IDX_OUT = 3'd1,
    IDX_POL = 3'd2,
    IDX_CFG = 3'd3
  } reg_idx_e;

endpackage

// File: rtl/gpio_xp_sync.sv
module gpio_xp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[g] <= '0;
        end else begin
          stg_q[g] <= stg_d[g];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_xp_regs.sv
module gpio_xp_regs
  import gpio_xp_pkg::*;
#(
  parameter int           W       = 8,
  parameter logic [W-1:0] OUT_RST = '1,
  parameter logic [W-1:0] POL_RST = '0,
  parameter logic [W-1:0] CFG_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  input  logic [W-1:0]     pin_sync,
  output logic [W-1:0]     rd_data,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     pol_q,
  output logic [W-1:0]     cfg_q,
  output logic [W-1:0]     cap_q,
  output logic             cap_load
);

  logic [W-1:0] out_d, pol_d, cfg_d, cap_d, rd_d, rd_q;
  logic         out_we, pol_we, cfg_we;

  // write decode: index 0 and unmapped indexes fall through to no enable
  always_comb begin
    out_we = 1'b0;
    pol_we = 1'b0;
    cfg_we = 1'b0;
    if (wr_en) begin
      case (reg_idx_e'(idx))
        IDX_OUT: out_we = 1'b1;
        IDX_POL: pol_we = 1'b1;
        IDX_CFG: cfg_we = 1'b1;
        default: ;
      endcase
    end
  end

  assign cap_load = rd_en && (reg_idx_e'(idx) == IDX_IN);

  always_comb begin
    out_d = out_we   ? wr_data  : out_q;
    pol_d = pol_we   ? wr_data  : pol_q;
    cfg_d = cfg_we   ? wr_data  : cfg_q;
    cap_d = cap_load ? pin_sync : cap_q;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      case (reg_idx_e'(idx))
        IDX_IN:  rd_d = pin_sync ^ pol_q;
        IDX_OUT: rd_d = out_q;
        IDX_POL: rd_d = pol_q;
        IDX_CFG: rd_d = cfg_q;
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= OUT_RST;
      pol_q <= POL_RST;
      cfg_q <= CFG_RST;
      cap_q <= '0;
      rd_q  <= '0;
    end else begin
      out_q <= out_d;
      pol_q <= pol_d;
      cfg_q <= cfg_d;
      cap_q <= cap_d;
      rd_q  <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/gpio_xp_irq.sv
module gpio_xp_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] cap_q,
  input  logic [W-1:0] cfg_q,
  input  logic         clr,
  output logic         irq_q
);

  logic [W-1:0] diff;
  logic         irq_d;

  // only input-direction pins take part in the comparison
  assign diff = (pin_sync ^ cap_q) & cfg_q;

  always_comb begin
    if (clr) begin
      irq_d = 1'b0;
    end else begin
      irq_d = |diff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/gpio_xp_core.sv
module gpio_xp_core
  import gpio_xp_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_oe,
  output logic [W-1:0]     pin_out,
  output logic             irq_pull
);

  logic [W-1:0] pin_sync;
  logic [W-1:0] out_q, pol_q, cfg_q, cap_q;
  logic         cap_load;
  logic         irq_q;

  gpio_xp_sync #(.W(W), .STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_xp_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (reg_idx),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .pin_sync (pin_sync),
    .rd_data  (rd_data),
    .out_q    (out_q),
    .pol_q    (pol_q),
    .cfg_q    (cfg_q),
    .cap_q    (cap_q),
    .cap_load (cap_load)
  );

  gpio_xp_irq #(.W(W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_sync),
    .cap_q    (cap_q),
    .cfg_q    (cfg_q),
    .clr      (cap_load),
    .irq_q    (irq_q)
  );

  assign pin_oe   = ~cfg_q;
  assign pin_out  = out_q;
  assign irq_pull = irq_q;

endmodule

// File: rtl/gpio_xp_core_chk.sv
module gpio_xp_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   reg_idx,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         rd_en,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_out,
  input logic         irq_pull,
  input logic [W-1:0] cap_q
);

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 3'd3) |=> (pin_oe == ~$past(wr_data)));

  assert_out_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 3'd1) |=> (pin_out == $past(wr_data)));

  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx > 3'd3) |=> (rd_data == '0));

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_idx0_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && reg_idx == 3'd0) |=> $stable(cap_q));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx == 3'd0) |=> !irq_pull);

  assert_out_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(pin_oe)) |-> !irq_pull);

endmodule

bind gpio_xp_core gpio_xp_core_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_idx  (reg_idx),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .pin_oe   (pin_oe),
  .pin_out  (pin_out),
  .irq_pull (irq_pull),
  .cap_q    (cap_q)
);

// File: tb/gpio_xp_core_bench.sv
module gpio_xp_core_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_idx;
  logic       wr_en, rd_en;
  logic [7:0] wr_data, rd_data, pin_in, pin_oe, pin_out;
  logic       irq_pull;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_xp_core u_gpio_xp_core (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .irq_pull(irq_pull)
  );

  // behavioural reference: pin history queue and plain register variables
  logic [7:0] hist[$];
  logic [7:0] m_out, m_pol, m_dir, m_cap, m_rd;
  bit         m_irq;

  function automatic logic [7:0] synced();
    return (hist.size() >= 2) ? hist[hist.size()-2] : 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      m_out = 8'hFF; m_pol = 8'h00; m_dir = 8'hFF;
      m_cap = 8'h00; m_rd = 8'h00; m_irq = 0;
    end else begin
      logic [7:0] s, n_out, n_pol, n_dir, n_cap, n_rd;
      bit n_irq;
      s = synced();
      n_out = m_out; n_pol = m_pol; n_dir = m_dir; n_cap = m_cap; n_rd = m_rd;
      n_irq = (((s ^ m_cap) & m_dir) != 0);
      if (rd_en) begin
        if (reg_idx == 0) begin
          n_rd = s ^ m_pol; n_cap = s; n_irq = 0;
        end else if (reg_idx == 1) n_rd = m_out;
        else if (reg_idx == 2) n_rd = m_pol;
        else if (reg_idx == 3) n_rd = m_dir;
        else n_rd = 8'h00;
      end
      if (wr_en) begin
        if (reg_idx == 1) n_out = wr_data;
        else if (reg_idx == 2) n_pol = wr_data;
        else if (reg_idx == 3) n_dir = wr_data;
      end
      hist.push_back(pin_in);
      if (hist.size() > 4) void'(hist.pop_front());
      m_out = n_out; m_pol = n_pol; m_dir = n_dir; m_cap = n_cap;
      m_rd = n_rd; m_irq = n_irq;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check("R4 rd_data vs model", rd_data, m_rd);
      check("R2 pin_oe vs model", pin_oe, ~m_dir);
      check("R3 pin_out vs model", pin_out, m_out);
      check("R7 irq_pull vs model", {7'b0, irq_pull}, {7'b0, m_irq});
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] i, logic [7:0] d);
    reg_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] i, output logic [7:0] d);
    reg_idx = i; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_idx = '0; wr_en = 0; rd_en = 0; wr_data = '0; pin_in = 8'h00;
    #(CLK_PERIOD * 3);
    check("R1 pin_oe in reset", pin_oe, 8'h00);
    check("R1 irq in reset", {7'b0, irq_pull}, 8'h00);
    check("R1 rd_data in reset", rd_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    rd(3'd1, v); check("R1 output default", v, 8'hFF);
    rd(3'd2, v); check("R1 polarity default", v, 8'h00);
    rd(3'd3, v); check("R1 direction default", v, 8'hFF);
    rd(3'd0, v); check("R1 input default", v, 8'h00);

    // R2 / R3
    wr(3'd3, 8'hF0); check("R2 pin_oe per bit", pin_oe, 8'h0F);
    wr(3'd1, 8'h5A); check("R3 pin_out", pin_out, 8'h5A);
    wr(3'd3, 8'hFF);

    // R5: index 0 write must not load captured register (would raise irq)
    wr(3'd0, 8'h77); idle(2);
    check("R5 idx0 write ignored", {7'b0, irq_pull}, 8'h00);
    wr(3'd5, 8'h00);
    rd(3'd1, v); check("R5 idx5 write ignored out", v, 8'h5A);
    rd(3'd2, v); check("R5 idx5 write ignored pol", v, 8'h00);
    rd(3'd3, v); check("R5 idx5 write ignored dir", v, 8'hFF);

    // R4 unmapped reads and hold
    rd(3'd6, v); check("R4 unmapped reads zero", v, 8'h00);
    idle(2); check("R4 rd_data held", rd_data, 8'h00);

    // R6 / R7 / R8 with polarity
    wr(3'd2, 8'h0F);
    pin_in = 8'h33; idle(4);
    check("R7 irq on change", {7'b0, irq_pull}, 8'h01);
    rd(3'd0, v); check("R6 inverted input read", v, 8'h3C);
    check("R8 read clears irq", {7'b0, irq_pull}, 8'h00);

    // R7 latency: single-bit change
    pin_in = 8'h31;
    idle(1); check("R7 not after 1 edge", {7'b0, irq_pull}, 8'h00);
    idle(1); check("R7 not after 2 edges", {7'b0, irq_pull}, 8'h00);
    idle(1); check("R7 set after 3 edges", {7'b0, irq_pull}, 8'h01);

    // R8 self-clear when pins return
    pin_in = 8'h33; idle(3);
    check("R8 clears on return", {7'b0, irq_pull}, 8'h00);

    // R9 output pins masked
    wr(3'd3, 8'h00);
    pin_in = 8'hFF; idle(5);
    check("R9 output pins no irq", {7'b0, irq_pull}, 8'h00);
    wr(3'd3, 8'hFF); idle(1);
    check("R9 irq after back to input", {7'b0, irq_pull}, 8'h01);
    rd(3'd0, v); check("R6 read after masking", v, 8'hF0);
    check("R8 cleared again", {7'b0, irq_pull}, 8'h00);

    idle(3);
    finish_run();
  end

endmodule